// File: doc/BRIEF.md
# Load Result Formatter

This block turns raw memory read data into the value written to the destination register of a fixed-point load. It receives up to sixteen bytes of read data in storage order and an access size and a formatting mode. From these it produces one 64-bit result. For quadword loads it produces two results, one for the even register and one for the odd register of a pair. Formatting covers zero extension, sign extension and byte reversal of halfwords, words and doublewords. A quadword is split across the register pair in an order set by an endian select. Bits follow most-significant-first numbering, so the byte at the lowest address supplies the top byte of any loaded value.

The block sits after the load data return in a pipeline. A request is presented with `in_valid`, and the formatted result appears one clock later with `out_valid`. Effective-address computation and memory timing belong to other blocks. A size and mode combination that has no meaning raises `err` and forces both results to zero.

Top module: `ldfmt_unit`

## Requirements
- R1: Mode code 0 (zero-extend) with size code 0, 1, 2 or 3 (1, 2, 4 or 8 bytes) places the first N bytes of `mem_data` in the low 8N bits of `res_even`, most significant byte first, and clears all bits above them. Memory byte k occupies `mem_data[127-8k -: 8]`.
- R2: Mode code 1 (sign-extend) with size code 1, 2 or 3 loads the value as in R1 and copies its top bit into every bit above it.
- R3: Mode code 2 (byte-reverse) with size code 1 puts memory byte 1 in `res_even[15:8]` and byte 0 in `res_even[7:0]`, and clears bits 63:16.
- R4: Mode code 2 with size code 2 puts memory byte k in `res_even[8k+7:8k]` for k = 0..3, and clears bits 63:32.
- R5: Mode code 2 with size code 3 puts memory byte k in `res_even[8k+7:8k]` for k = 0..7.
- R6: Mode code 3 (register pair) with size code 4 and `big_endian`=1 gives `res_even` = bytes 0..7 and `res_odd` = bytes 8..15, each most significant byte first.
- R7: Mode code 3 with size code 4 and `big_endian`=0 gives `res_even` = bytes 8..15 byte-reversed (byte 8 lowest), and `res_odd` = bytes 0..7 byte-reversed (byte 0 lowest).
- R8: For every request that is not a register-pair request, `res_odd` is zero.
- R9: Some requests are illegal: size codes 5 to 7; mode 3 with any size other than 4; any other mode with size 4; and modes 1 or 2 with size 0. An illegal request sets `err` and drives both results to zero. Every legal request clears `err`.
- R10: A request with `in_valid` high shows its results with `out_valid` high after exactly one rising clock edge. A cycle with `in_valid` low drops `out_valid` and leaves `res_even`, `res_odd` and `err` unchanged.
- R11: While `rst_n` is low, `out_valid`, `err`, `res_even` and `res_odd` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| mem_data | input | 128 | Read data, byte 0 in bits 127:120 |
| size | input | 3 | Access size code: 0..4 = 1, 2, 4, 8, 16 bytes |
| mode | input | 2 | 0 zero-extend, 1 sign-extend, 2 byte-reverse, 3 register pair |
| big_endian | input | 1 | Pair ordering select, used in mode 3 only |
| out_valid | output | 1 | Results valid |
| err | output | 1 | Illegal size/mode combination |
| res_even | output | 64 | Single result or even register of a pair |
| res_odd | output | 64 | Odd register of a pair, zero otherwise |

## Verification
The bench sweeps every size code, mode code and endian setting against data patterns. Some patterns have the top bit of byte 0 set and some have it clear, so a sign extension taken from the wrong bit, or from a fixed width, shows up as wrong upper bits. Pair requests in both endian settings catch swapped registers and reversal applied to the wrong doubleword. Every illegal combination is checked for zero results, which catches a design that leaks partly formatted data while raising `err`. Idle cycles between requests catch results that keep updating when no request is present.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;
  localparam int REG_W  = 64;
  localparam int BYTE_W = 8;
  localparam int LANES  = REG_W / BYTE_W;

  localparam logic [2:0] SZ_BYTE = 3'd0;
  localparam logic [2:0] SZ_HALF = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;
  localparam logic [2:0] SZ_DBL  = 3'd3;
  localparam logic [2:0] SZ_QUAD = 3'd4;

  localparam logic [1:0] MD_ZERO = 2'd0;
  localparam logic [1:0] MD_SIGN = 2'd1;
  localparam logic [1:0] MD_REV  = 2'd2;
  localparam logic [1:0] MD_PAIR = 2'd3;

  // byte count of a single-register access, clipped to one register
  function automatic logic [4:0] lane_count(input logic [2:0] sz);
    lane_count = (sz > SZ_DBL) ? 5'(LANES) : 5'(1 << sz);
  endfunction

  // value right-aligned in the low n bytes; sign bit copied upward
  function automatic logic [REG_W-1:0] sign_fill(input logic [REG_W-1:0] x,
                                                 input logic [4:0] n);
    int top;
    top = BYTE_W * int'(n) - 1;
    for (int j = 0; j < REG_W; j++)
      sign_fill[j] = (j <= top) ? x[j] : x[top];
  endfunction

  // reverse the order of the low n bytes, zero above them
  function automatic logic [REG_W-1:0] swap_lanes(input logic [REG_W-1:0] x,
                                                  input logic [4:0] n);
    swap_lanes = '0;
    for (int i = 0; i < LANES; i++)
      if (i < int'(n))
        swap_lanes[BYTE_W*i +: BYTE_W] = x[BYTE_W*(int'(n)-1-i) +: BYTE_W];
  endfunction

  function automatic logic combo_legal(input logic [2:0] sz, input logic [1:0] md);
    if (sz > SZ_QUAD)                         combo_legal = 1'b0;
    else if ((md == MD_PAIR) != (sz == SZ_QUAD)) combo_legal = 1'b0;
    else if ((md == MD_SIGN || md == MD_REV) && sz == SZ_BYTE) combo_legal = 1'b0;
    else                                      combo_legal = 1'b1;
  endfunction
endpackage

// File: rtl/ldfmt_single.sv
module ldfmt_single
  import ldfmt_pkg::*;
(
  input  logic [REG_W-1:0] first_dw,
  input  logic [2:0]       size,
  input  logic [1:0]       mode,
  output logic [REG_W-1:0] value
);
  logic [4:0]       nbytes;
  logic [REG_W-1:0] aligned;

  always_comb begin
    nbytes  = lane_count(size);
    aligned = first_dw >> (REG_W - BYTE_W * int'(nbytes));
    unique case (mode)
      MD_ZERO: value = aligned;
      MD_SIGN: value = sign_fill(aligned, nbytes);
      MD_REV:  value = swap_lanes(aligned, nbytes);
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/ldfmt_pair.sv
module ldfmt_pair
  import ldfmt_pkg::*;
(
  input  logic [2*REG_W-1:0] mem_data,
  input  logic               big_endian,
  output logic [REG_W-1:0]   even_val,
  output logic [REG_W-1:0]   odd_val
);
  logic [REG_W-1:0] dw_lo_addr, dw_hi_addr, rv_lo_addr, rv_hi_addr;

  assign dw_lo_addr = mem_data[2*REG_W-1 -: REG_W];
  assign dw_hi_addr = mem_data[REG_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rv_lo_addr[BYTE_W*g +: BYTE_W] = dw_lo_addr[BYTE_W*(LANES-1-g) +: BYTE_W];
    assign rv_hi_addr[BYTE_W*g +: BYTE_W] = dw_hi_addr[BYTE_W*(LANES-1-g) +: BYTE_W];
  end

  assign even_val = big_endian ? dw_lo_addr : rv_hi_addr;
  assign odd_val  = big_endian ? dw_hi_addr : rv_lo_addr;
endmodule

// File: rtl/ldfmt_unit.sv
module ldfmt_unit
  import ldfmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2*REG_W-1:0]   mem_data,
  input  logic [2:0]           size,
  input  logic [1:0]           mode,
  input  logic                 big_endian,
  output logic                 out_valid,
  output logic                 err,
  output logic [REG_W-1:0]     res_even,
  output logic [REG_W-1:0]     res_odd
);
  logic             comb_err;
  logic             is_pair;
  logic [REG_W-1:0] single_val, pair_even, pair_odd;
  logic [REG_W-1:0] comb_even, comb_odd;

  ldfmt_single single_i (
    .first_dw (mem_data[2*REG_W-1 -: REG_W]),
    .size     (size),
    .mode     (mode),
    .value    (single_val)
  );

  ldfmt_pair pair_i (
    .mem_data   (mem_data),
    .big_endian (big_endian),
    .even_val   (pair_even),
    .odd_val    (pair_odd)
  );

  assign comb_err  = !combo_legal(size, mode);
  assign is_pair   = (mode == MD_PAIR);
  assign comb_even = comb_err ? '0 : (is_pair ? pair_even : single_val);
  assign comb_odd  = (comb_err || !is_pair) ? '0 : pair_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      res_even  <= '0;
      res_odd   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        err      <= comb_err;
        res_even <= comb_even;
        res_odd  <= comb_odd;
      end
    end
  end
endmodule

module ldfmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  size,
  input logic [1:0]  mode,
  input logic        out_valid,
  input logic        err,
  input logic [63:0] res_even,
  input logic [63:0] res_odd
);
  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(res_even) && $stable(res_odd) && $stable(err)));
  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (res_even == 64'd0 && res_odd == 64'd0));
  // R8
  odd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode != 2'd3) |=> res_odd == 64'd0);
  // R1
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0 && size == 3'd0) |=> res_even[63:8] == 56'd0);
  // R2
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd1 && size == 3'd2) |=> res_even[63:32] == {32{res_even[31]}});
  // R3
  half_rev_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd2 && size == 3'd1) |=> res_even[63:16] == 48'd0);
  // R11
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !err && res_even == 64'd0 && res_odd == 64'd0));
endmodule

bind ldfmt_unit ldfmt_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .size      (size),
  .mode      (mode),
  .out_valid (out_valid),
  .err       (err),
  .res_even  (res_even),
  .res_odd   (res_odd)
);

// File: tb/ldfmt_unit_tb.sv
module ldfmt_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPAT       = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] mem_data = '0;
  logic [2:0]   size = '0;
  logic [1:0]   mode = '0;
  logic         big_endian = 1'b0;
  logic         out_valid, err;
  logic [63:0]  res_even, res_odd;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldfmt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mem_data(mem_data),
    .size(size), .mode(mode), .big_endian(big_endian),
    .out_valid(out_valid), .err(err), .res_even(res_even), .res_odd(res_odd)
  );

  function automatic logic [127:0] make_pat(input int k);
    logic [7:0] b;
    make_pat = '0;
    for (int i = 0; i < 16; i++) begin
      b = 8'((k * 37 + i * 29 + 17) & 255);
      if (i == 0) b = (k % 2 == 1) ? (b | 8'h80) : (b & 8'h7f);
      if (k == NPAT - 1) b = 8'hff;
      make_pat[127 - 8*i -: 8] = b;
    end
  endfunction

  task automatic expect_of(input logic [127:0] d, input logic [2:0] sz,
                           input logic [1:0] md, input logic be,
                           output logic e_err, output logic [63:0] e_ev,
                           output logic [63:0] e_od);
    logic [7:0]  m [16];
    logic [63:0] da, db, ra, rb;
    int n;
    logic legal;
    for (int i = 0; i < 16; i++) m[i] = d[127 - 8*i -: 8];
    legal = (sz <= 3'd4) && ((md == 2'd3) == (sz == 3'd4)) &&
            !((md == 2'd1 || md == 2'd2) && sz == 3'd0);
    e_err = !legal; e_ev = '0; e_od = '0;
    n = 1 << sz;
    if (legal) begin
      case (md)
        2'd0, 2'd1: begin
          for (int i = 0; i < n; i++) e_ev |= {56'd0, m[i]} << (8*(n-1-i));
          if (md == 2'd1 && m[0][7] && n < 8) e_ev |= ~64'd0 << (8*n);
        end
        2'd2: for (int i = 0; i < n; i++) e_ev |= {56'd0, m[i]} << (8*i);
        default: begin
          da = '0; db = '0; ra = '0; rb = '0;
          for (int i = 0; i < 8; i++) begin
            da |= {56'd0, m[i]}   << (8*(7-i));
            db |= {56'd0, m[8+i]} << (8*(7-i));
            ra |= {56'd0, m[i]}   << (8*i);
            rb |= {56'd0, m[8+i]} << (8*i);
          end
          if (be) begin e_ev = da; e_od = db; end
          else    begin e_ev = rb; e_od = ra; end
        end
      endcase
    end
  endtask

  function automatic string tag_of(input logic e_err, input logic [2:0] sz,
                                   input logic [1:0] md, input logic be);
    if (e_err) return "R9";
    case (md)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return (sz == 3'd1) ? "R3" : (sz == 3'd2) ? "R4" : "R5";
      default: return be ? "R6" : "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic        e_err;
    logic [63:0] e_ev, e_od;
    string       t;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {61'd0, out_valid, err, |res_even}, 64'd0, "reset flags");
    check("R11", res_odd, 64'd0, "reset odd");
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NPAT; k++)
      for (int s = 0; s < 8; s++)
        for (int md = 0; md < 4; md++)
          for (int be = 0; be < 2; be++) begin
            mem_data = make_pat(k); size = 3'(s); mode = 2'(md);
            big_endian = 1'(be); in_valid = 1'b1;
            expect_of(mem_data, size, mode, big_endian, e_err, e_ev, e_od);
            t = tag_of(e_err, size, mode, big_endian);
            @(negedge clk);
            check("R10", {63'd0, out_valid}, 64'd1, "out_valid after request");
            check(t, {63'd0, err}, {63'd0, e_err}, "err");
            check(t, res_even, e_ev, "even");
            check((md == 3) ? t : "R8", res_odd, e_od, "odd");
            // idle cycle with disturbed inputs: R10 hold
            in_valid = 1'b0; mem_data = ~mem_data; size = 3'd0; mode = 2'd0;
            @(negedge clk);
            check("R10", {63'd0, out_valid}, 64'd0, "out_valid idle");
            check("R10", res_even, e_ev, "even held");
            check("R10", res_odd, e_od, "odd held");
            check("R10", {63'd0, err}, {63'd0, e_err}, "err held");
          end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule